// File: doc/BRIEF.md
# Four-Port GPIO Controller with Edge Interrupts

The block drives and samples four ports of eight pins each and is programmed over a small synchronous register bus. A configuration register gives every port a 2-bit drive mode. The mode sets how the pins are driven: push-pull, open-drain, or open-drain with a weak pull-up. It also sets whether the port can raise interrupts, and on which edge.

Each pin has its own interrupt enable bit. Pin inputs are synchronised, and qualifying edges set sticky pending flags. Software clears a flag by writing a one to it. All pending flags are ORed into one interrupt request. A separate interface-mode input models a parallel host interface taking over the ports. While it is high, no edge is captured and the request is held low, on every port.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The drive-mode register is read and written at address 0x08, with port p's mode in bits [2p+1:2p]. Reset clears it to 0, so every port starts in mode 00.
- R2: In mode 11, every pin of the port is driven (pad_oe = 1), pad_out equals the output latch bit, and pad_pu = 0.
- R3: In modes 00 and 01, pad_out = 0, pad_oe is the inverse of the latch bit, and pad_pu = 0. A latch 0 pulls the pin low, and a latch 1 releases it.
- R4: In mode 10, the drive is as in R3 but pad_pu = 1 on every pin of the port.
- R5: A write to address p (0 to 3) loads port p's output latch, which resets to all ones. A read of address p returns pad_in for that port after a two-flop synchroniser, two clock edges after the pin changes.
- R6: Addresses 0x04 to 0x07 hold the per-pin interrupt enables of ports 0 to 3. They are write-only and read back 0. Reset clears them. Unused addresses 0x09 to 0x0B also read 0.
- R7: In mode 00 a rising edge of a synchronised pin is captured, and in modes 01 and 10 a falling edge is captured. A captured edge on an enabled pin sets its pending bit on the third clock edge after the pin changes.
- R8: A port in mode 11 never sets a pending bit.
- R9: Pending bits are read at 0x0C + p. They stay set until a write of a 1 to that bit at that address. An edge captured in the same cycle as the clearing write leaves the bit set. Pins whose enable bit is 0 never become pending.
- R10: irq is the OR of all pending bits while iface_mode is 0. While iface_mode is 1, irq is 0 and no new pending bit is set on any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pin levels, port p in bits [8p+7:8p] |
| pad_out | output | 32 | Value driven when enabled |
| pad_oe | output | 32 | Driver enable per pin |
| pad_pu | output | 32 | Pull-up enable per pin |
| iface_mode | input | 1 | Parallel interface active: blocks all pin interrupts |
| irq | output | 1 | Shared interrupt request |

## Verification
Directed steps give each port a different mode. Rising and falling pin steps are then applied, so a wrong polarity shows up as a pending bit on the wrong edge, and push-pull ports are shown to stay silent. One step places a clearing write in the same cycle as a captured edge, which separates set-over-clear from clear-over-set. Interface mode is raised while a bit is already pending and while new edges arrive, which separates masking the request from blocking capture. A seeded random phase then mixes pin toggles, mode, enable and latch writes, acknowledges and interface-mode changes. Every pad output, the request and a random register read are compared each cycle with a bench model.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Per-port drive mode. Encoding is fixed by the register layout.
    typedef enum logic [1:0] {
        MODE_OD_RISE     = 2'b00,  // open-drain, rising-edge interrupt
        MODE_OD_FALL     = 2'b01,  // open-drain, falling-edge interrupt
        MODE_PULLUP_FALL = 2'b10,  // open-drain with pull-up, falling edge
        MODE_PUSH_PULL   = 2'b11   // always driven, no interrupt
    } pin_mode_e;

endpackage

// File: rtl/gpio_mode_decode.sv
module gpio_mode_decode
    import gpio_irq_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  pin_mode_e         mode_i,
    input  logic [PORT_W-1:0] latch_i,
    output logic [PORT_W-1:0] out_o,
    output logic [PORT_W-1:0] oe_o,
    output logic [PORT_W-1:0] pu_o,
    output logic              sel_rise_o,
    output logic              sel_fall_o
);

    always_comb begin
        out_o      = '0;
        oe_o       = ~latch_i;   // open-drain: only a 0 is driven (R3)
        pu_o       = '0;
        sel_rise_o = 1'b0;
        sel_fall_o = 1'b0;
        unique case (mode_i)
            MODE_OD_RISE: begin
                sel_rise_o = 1'b1;
            end
            MODE_OD_FALL: begin
                sel_fall_o = 1'b1;
            end
            MODE_PULLUP_FALL: begin
                pu_o       = '1;   // R4
                sel_fall_o = 1'b1;
            end
            MODE_PUSH_PULL: begin
                oe_o  = '1;        // R2
                out_o = latch_i;
            end
            default: begin
                oe_o = ~latch_i;
            end
        endcase
    end

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_i,
    input  logic [PORT_W-1:0] ien_i,
    input  logic              sel_rise_i,
    input  logic              sel_fall_i,
    input  logic              block_i,
    input  logic [PORT_W-1:0] ack_i,
    output logic [PORT_W-1:0] level_o,
    output logic [PORT_W-1:0] pend_o
);

    typedef struct packed {
        logic [PORT_W-1:0] s1;
        logic [PORT_W-1:0] s2;
        logic [PORT_W-1:0] prev;
        logic [PORT_W-1:0] pend;
    } edge_st_t;

    edge_st_t          st_d, st_q;
    logic [PORT_W-1:0] rise, fall, cap;

    always_comb begin
        st_d = st_q;
        rise = st_q.s2 & ~st_q.prev;
        fall = ~st_q.s2 & st_q.prev;
        // R7 polarity, R9 enable gate, R10 interface block
        cap  = ((rise & {PORT_W{sel_rise_i}}) | (fall & {PORT_W{sel_fall_i}}))
               & ien_i & {PORT_W{~block_i}};
        // R9: capture wins over a same-cycle clear
        st_d.pend = (st_q.pend & ~ack_i) | cap;
        st_d.prev = st_q.s2;
        st_d.s2   = st_q.s1;
        st_d.s1   = pin_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.s2;
    assign pend_o  = st_q.pend;

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_o) & ~$past(ack_i)) & ~pend_o) == '0));

    p_enable_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(ien_i)) == '0));

    p_block_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
        block_i |=> ((pend_o & ~$past(pend_o)) == '0));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int IEN_BASE  = 4,
    parameter int CFG_ADDR  = 8,
    parameter int PEND_BASE = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [PORT_W-1:0]             wdata_i,
    output logic [NUM_PORTS*PORT_W-1:0]   latch_o,
    output logic [NUM_PORTS*PORT_W-1:0]   ien_o,
    output logic [2*NUM_PORTS-1:0]        cfg_o,
    output logic [NUM_PORTS*PORT_W-1:0]   ack_o
);

    localparam int PINS  = NUM_PORTS * PORT_W;
    localparam int CFG_W = 2 * NUM_PORTS;

    typedef struct packed {
        logic [PINS-1:0]  latch;
        logic [PINS-1:0]  ien;
        logic [CFG_W-1:0] cfg;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        ack_o = '0;
        if (wr_i) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (addr_i == ADDR_W'(p))
                    st_d.latch[p*PORT_W +: PORT_W] = wdata_i;
                if (addr_i == ADDR_W'(IEN_BASE + p))
                    st_d.ien[p*PORT_W +: PORT_W] = wdata_i;
                if (addr_i == ADDR_W'(PEND_BASE + p))
                    ack_o[p*PORT_W +: PORT_W] = wdata_i;
            end
            if (addr_i == ADDR_W'(CFG_ADDR))
                st_d.cfg = wdata_i[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.latch <= '1;   // R5: pins released after reset
            st_q.ien   <= '0;   // R6
            st_q.cfg   <= '0;   // R1
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_o = st_q.latch;
    assign ien_o   = st_q.ien;
    assign cfg_o   = st_q.cfg;

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i || addr_i >= ADDR_W'(NUM_PORTS)) |=> $stable(latch_o));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 8,
    parameter int ADDR_W    = $clog2(4 * NUM_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [PORT_W-1:0]           bus_wdata,
    output logic [PORT_W-1:0]           bus_rdata,
    input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
    output logic [NUM_PORTS*PORT_W-1:0] pad_out,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pad_pu,
    input  logic                        iface_mode,
    output logic                        irq
);

    localparam int PINS      = NUM_PORTS * PORT_W;
    localparam int CFG_W     = 2 * NUM_PORTS;
    localparam int IEN_BASE  = NUM_PORTS;
    localparam int CFG_ADDR  = 2 * NUM_PORTS;
    localparam int PEND_BASE = 3 * NUM_PORTS;

    logic [PINS-1:0]  latch, ien, ack, level, pend;
    logic [CFG_W-1:0] cfg;

    gpio_regs #(
        .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .ADDR_W(ADDR_W),
        .IEN_BASE(IEN_BASE), .CFG_ADDR(CFG_ADDR), .PEND_BASE(PEND_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .latch_o(latch), .ien_o(ien), .cfg_o(cfg),
        .ack_o(ack)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        pin_mode_e mode;
        logic      sel_rise, sel_fall;

        assign mode = pin_mode_e'(cfg[2*p +: 2]);

        gpio_mode_decode #(.PORT_W(PORT_W)) u_dec (
            .mode_i(mode), .latch_i(latch[p*PORT_W +: PORT_W]),
            .out_o(pad_out[p*PORT_W +: PORT_W]),
            .oe_o(pad_oe[p*PORT_W +: PORT_W]),
            .pu_o(pad_pu[p*PORT_W +: PORT_W]),
            .sel_rise_o(sel_rise), .sel_fall_o(sel_fall)
        );

        gpio_edge_unit #(.PORT_W(PORT_W)) u_edge (
            .clk(clk), .rst_n(rst_n),
            .pin_i(pad_in[p*PORT_W +: PORT_W]),
            .ien_i(ien[p*PORT_W +: PORT_W]),
            .sel_rise_i(sel_rise), .sel_fall_i(sel_fall),
            .block_i(iface_mode),
            .ack_i(ack[p*PORT_W +: PORT_W]),
            .level_o(level[p*PORT_W +: PORT_W]),
            .pend_o(pend[p*PORT_W +: PORT_W])
        );

        p_push_pull_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == MODE_PUSH_PULL) |=>
            ((pend[p*PORT_W +: PORT_W] & ~$past(pend[p*PORT_W +: PORT_W])) == '0));
    end

    // Register read mux (R1, R5, R6, R9)
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (bus_addr == ADDR_W'(p))
                bus_rdata = level[p*PORT_W +: PORT_W];
            if (bus_addr == ADDR_W'(PEND_BASE + p))
                bus_rdata = pend[p*PORT_W +: PORT_W];
        end
        if (bus_addr == ADDR_W'(CFG_ADDR))
            bus_rdata[CFG_W-1:0] = cfg;
    end

    // R10: shared request, masked by the interface mode
    assign irq = (|pend) & ~iface_mode;

endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [31:0] pins = '0;
    logic [31:0] pad_out, pad_oe, pad_pu;
    logic        iface = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_ctrl u_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pins),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .iface_mode(iface), .irq(irq)
    );

    // Reference model state
    logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [31:0] m_lat = '1, m_ien = '0, m_pend = '0;
    logic [7:0]  m_cfg = '0;

    function automatic void model_clk(logic w, logic [3:0] a, logic [7:0] d,
                                      logic [31:0] pin, logic blk);
        logic [31:0] cap = '0;
        logic [31:0] ack = '0;
        for (int p = 0; p < 4; p++) begin
            logic [1:0] md  = m_cfg[2*p +: 2];
            logic [7:0] r   = m_s2[p*8 +: 8] & ~m_prev[p*8 +: 8];
            logic [7:0] f   = ~m_s2[p*8 +: 8] & m_prev[p*8 +: 8];
            logic [7:0] sel = (md == 2'b00) ? r : ((md == 2'b11) ? 8'h00 : f);
            cap[p*8 +: 8] = sel & m_ien[p*8 +: 8] & {8{~blk}};
            if (w && a == 4'(12 + p)) ack[p*8 +: 8] = d;
        end
        m_pend = (m_pend & ~ack) | cap;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pin;
        if (w) begin
            if (a < 4)                m_lat[a[1:0]*8 +: 8] = d;
            else if (a < 8)           m_ien[a[1:0]*8 +: 8] = d;
            else if (a == 4'd8)       m_cfg = d;
        end
    endfunction

    function automatic logic [7:0] exp_read(logic [3:0] a);
        if (a < 4)        return m_s2[a[1:0]*8 +: 8];
        if (a == 4'd8)    return m_cfg;
        if (a >= 4'd12)   return m_pend[a[1:0]*8 +: 8];
        return 8'h00;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_pads();
        logic [31:0] eo = '0, ep = '0, eu = '0;
        for (int p = 0; p < 4; p++) begin
            logic [1:0] md = m_cfg[2*p +: 2];
            if (md == 2'b11) begin
                eo[p*8 +: 8] = 8'hFF;
                ep[p*8 +: 8] = m_lat[p*8 +: 8];
            end else begin
                eo[p*8 +: 8] = ~m_lat[p*8 +: 8];
                if (md == 2'b10) eu[p*8 +: 8] = 8'hFF;
            end
        end
        chk("R2 R3 R4 pad_oe", pad_oe, eo);
        chk("R2 R3 pad_out", pad_out, ep);
        chk("R3 R4 pad_pu", pad_pu, eu);
        chk("R10 irq", {31'b0, irq}, {31'b0, (|m_pend) & ~iface});
    endtask

    // One clock: inputs applied at negedge, model stepped at posedge,
    // outputs compared at the following negedge.
    task automatic tick(logic w, logic [3:0] a, logic [7:0] d);
        bus_wr = w; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_clk(w, a, d, pins, iface);
        @(negedge clk);
        bus_wr = 1'b0;
        compare_pads();
    endtask

    task automatic rd(string tag, logic [3:0] a, logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, {24'b0, bus_rdata}, {24'b0, exp});
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, 4'd0, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        compare_pads();
        rd("R1 cfg reset", 4'd8, 8'h00);
        rd("R6 enable read zero", 4'd5, 8'h00);
        chk("R5 latch reset releases pins", pad_oe, 32'h0);

        // Modes: port0=00, port1=01, port2=10, port3=11
        tick(1'b1, 4'd8, 8'hE4);
        rd("R1 cfg readback", 4'd8, 8'hE4);
        for (int p = 0; p < 4; p++) tick(1'b1, 4'(p), 8'h5A);
        chk("R2 push-pull oe", {24'b0, pad_oe[31:24]}, 32'hFF);
        chk("R2 push-pull out", {24'b0, pad_out[31:24]}, 32'h5A);
        chk("R4 pull-up on", {24'b0, pad_pu[23:16]}, 32'hFF);
        chk("R3 open-drain oe", {24'b0, pad_oe[15:8]}, 32'hA5);

        // Rising edge on port 0
        tick(1'b1, 4'd4, 8'h01);
        pins[0] = 1'b1;
        idle(2);
        rd("R7 not yet pending", 4'd12, 8'h00);
        idle(1);
        rd("R7 rising pending", 4'd12, 8'h01);
        chk("R10 irq asserted", {31'b0, irq}, 32'h1);
        rd("R5 synced level", 4'd0, 8'h01);
        tick(1'b1, 4'd12, 8'h01);
        rd("R9 acknowledge clears", 4'd12, 8'h00);

        // Falling edge on port 1
        tick(1'b1, 4'd5, 8'h01);
        pins[8] = 1'b1; idle(4);
        rd("R7 rising ignored in mode 01", 4'd13, 8'h00);
        pins[8] = 1'b0; idle(4);
        rd("R7 falling pending", 4'd13, 8'h01);

        // Push-pull port never pends
        tick(1'b1, 4'd7, 8'hFF);
        pins[31:24] = 8'hFF; idle(4);
        pins[31:24] = 8'h00; idle(4);
        rd("R8 push-pull no pending", 4'd15, 8'h00);

        // Disabled pin does not pend
        pins[1] = 1'b1; idle(4);
        rd("R9 disabled pin", 4'd12, 8'h00);

        // Interface mode
        iface = 1'b1; #1;
        chk("R10 irq masked", {31'b0, irq}, 32'h0);
        pins[0] = 1'b0; idle(3);
        pins[0] = 1'b1; idle(4);
        rd("R10 capture blocked", 4'd12, 8'h00);
        iface = 1'b0; #1;
        chk("R10 irq returns", {31'b0, irq}, 32'h1);
        tick(1'b1, 4'd13, 8'hFF);

        // Edge in the same cycle as the acknowledge
        pins[0] = 1'b0; idle(4);
        pins[0] = 1'b1;
        idle(2);
        rd("R9 pre-collision clear", 4'd12, 8'h00);
        tick(1'b1, 4'd12, 8'h01);
        rd("R9 set wins over clear", 4'd12, 8'h01);
        rd("R6 unused addr", 4'd10, 8'h00);

        // Seeded random phase
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 9);
            if ($urandom_range(0, 3) == 0) pins ^= $urandom & $urandom;
            if ($urandom_range(0, 40) == 0) iface = ~iface;
            case (op)
                0: tick(1'b1, 4'd8, 8'($urandom));
                1: tick(1'b1, 4'($urandom_range(4, 7)), 8'($urandom));
                2: tick(1'b1, 4'($urandom_range(0, 3)), 8'($urandom));
                3: tick(1'b1, 4'($urandom_range(12, 15)), 8'($urandom));
                default: tick(1'b0, 4'd0, 8'h00);
            endcase
            begin
                logic [3:0] ra = 4'($urandom);
                rd("R1 R5 R6 R9 random read", ra, exp_read(ra));
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule